// File: doc/BRIEF.md
# SIMT Divergence Mask Unit

This block keeps the active-thread mask and program counter of one warp of lockstep threads as that warp meets conditional branches. An issue stage reads the current mask and PC every cycle and reports control events back: a launch that starts the warp, a sequential advance, a branch with its per-thread condition vector, an else-switch at the end of a taken path, a reconverge at a join point, and a barrier request. A branch splits the active threads into a taken group and a not-taken group. The taken group runs first while every other thread is masked off. The not-taken group runs next. At the join point the mask that held before the branch is restored.

Nested divergence is held on a small reconvergence stack. Each level stores the join PC, the PC and mask of the pending not-taken path, the pre-branch mask and a phase bit. A branch whose condition agrees across all active threads costs no stack entry and runs only the single path the threads take. Else-switch and reconverge events carry the join PC of the branch they close. They act only when that PC matches the top stack entry, so the closing events of uniform branches are harmless. The control is a three-state machine. IDLE holds no warp. CONV means converged, with an empty stack. DIV means diverged, with at least one entry on the stack. A launch moves any state to CONV. A divergent branch moves CONV or DIV to DIV. The pop of the last entry moves DIV back to CONV.

Top module: `dv_mask_unit`

## Requirements
- R1: After reset the unit is in IDLE: issue_valid, active_mask, cur_pc, stack_depth, diverged, uniform_br, stack_ovf and barrier_err are all zero.
- R2: A launch with a non-zero mask loads active_mask and the warp mask from launch_mask and cur_pc from launch_pc, clears the stack and stack_ovf, and enters CONV on the next cycle. A launch with an all-zero mask changes nothing.
- R3: An advance in CONV or DIV adds PC_STEP to cur_pc and leaves the mask unchanged.
- R4: A divergent branch (taken mask = active & cond and not-taken mask = active & ~cond, both non-zero) pushes one entry, sets active_mask to the taken mask and cur_pc to br_taken_pc, and raises diverged.
- R5: A uniform branch (not-taken mask zero, or taken mask zero) pushes nothing and keeps active_mask. It sets cur_pc to br_taken_pc when every active thread takes it and to br_else_pc when none does, and pulses uniform_br for one cycle.
- R6: An else-switch whose evt_join_pc equals the top entry's join PC, while that entry is still in its taken phase, sets active_mask to the saved not-taken mask and cur_pc to the saved else PC. A non-matching or repeated else-switch changes nothing.
- R7: A matching reconverge in the taken phase acts as an else-switch. In the not-taken phase it pops the entry and restores the pre-branch mask, with cur_pc set to the join PC. A non-matching reconverge changes nothing.
- R8: Nested divergent branches stack up to STACK_DEPTH levels and are unwound last-in first-out, stack_depth reporting the level count.
- R9: A divergent branch with the stack full sets the sticky stack_ovf flag and leaves mask, PC and depth unchanged. A uniform branch at full depth proceeds normally.
- R10: A barrier request while the unit holds a warp and active_mask differs from the launched warp mask pulses barrier_err on the next cycle. With the full warp active it raises no error.
- R11: When several events are asserted in one cycle only the highest acts, in the order launch, branch, else-switch, reconverge, advance. Events other than launch have no effect in IDLE.
- R12: Whenever issue_valid is high, active_mask is non-zero and a subset of the launched warp mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Start a warp |
| launch_mask | input | NUM_THREADS | Threads present in the warp |
| launch_pc | input | PC_W | First PC of the warp |
| adv_valid | input | 1 | Sequential advance of the PC |
| br_valid | input | 1 | Conditional branch event |
| br_cond | input | NUM_THREADS | Per-thread branch outcome, 1 = taken |
| br_taken_pc | input | PC_W | Start of the taken path |
| br_else_pc | input | PC_W | Start of the not-taken path |
| br_join_pc | input | PC_W | Reconvergence PC of the branch |
| else_valid | input | 1 | End of a taken path |
| reconv_valid | input | 1 | Join point reached |
| evt_join_pc | input | PC_W | Join PC named by else-switch or reconverge |
| barrier_req | input | 1 | Barrier instruction seen |
| issue_valid | output | 1 | A warp is held and may issue |
| active_mask | output | NUM_THREADS | Threads enabled for the current instruction |
| cur_pc | output | PC_W | PC of the current instruction |
| diverged | output | 1 | Unit is in DIV |
| stack_depth | output | $clog2(STACK_DEPTH+1) | Number of stacked levels |
| uniform_br | output | 1 | One-cycle pulse after a uniform branch |
| stack_ovf | output | 1 | Sticky overflow flag |
| barrier_err | output | 1 | One-cycle pulse after an illegal barrier |

## Verification
The bench builds the unit with 32 threads, 32-bit PCs, a PC step of 4 and a stack depth of 4. The full-width masks exercise every thread bit. The shallow stack lets a fifth nested divergent branch reach the overflow path, and a uniform branch at full depth, within a short run. Nested sequences mix divergent and uniform branches with matching and non-matching join PCs, so both phases of the LIFO unwinding are observed at the ports. Same-cycle event combinations probe the priority order.

// File: rtl/dv_pkg.sv
package dv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DIV  = 2'd2
    } dv_state_e;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_LAUNCH = 3'd1,
        EV_BRANCH = 3'd2,
        EV_ELSE   = 3'd3,
        EV_RECONV = 3'd4,
        EV_ADV    = 3'd5
    } dv_event_e;

endpackage

// File: rtl/dv_evt_arb.sv
module dv_evt_arb
    import dv_pkg::*;
(
    input  logic      launch_valid,
    input  logic      br_valid,
    input  logic      else_valid,
    input  logic      reconv_valid,
    input  logic      adv_valid,
    output dv_event_e ev
);

    // Fixed priority: one event acts per cycle (R11)
    always_comb begin
        if (launch_valid)      ev = EV_LAUNCH;
        else if (br_valid)     ev = EV_BRANCH;
        else if (else_valid)   ev = EV_ELSE;
        else if (reconv_valid) ev = EV_RECONV;
        else if (adv_valid)    ev = EV_ADV;
        else                   ev = EV_NONE;
    end

endmodule

// File: rtl/dv_split.sv
module dv_split #(
    parameter int NT = 32
) (
    input  logic [NT-1:0] active,
    input  logic [NT-1:0] cond,
    output logic [NT-1:0] taken_mask,
    output logic [NT-1:0] ntaken_mask,
    output logic          all_taken,
    output logic          none_taken
);

    for (genvar i = 0; i < NT; i++) begin : g_lane
        assign taken_mask[i]  = active[i] & cond[i];
        assign ntaken_mask[i] = active[i] & ~cond[i];
    end

    assign all_taken  = (ntaken_mask == '0);
    assign none_taken = (taken_mask == '0);

endmodule

// File: rtl/dv_stack.sv
module dv_stack #(
    parameter int NT    = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic [PC_W-1:0] push_join,
    input  logic [PC_W-1:0] push_epc,
    input  logic [NT-1:0]   push_emask,
    input  logic [NT-1:0]   push_pre,
    input  logic            pop,
    input  logic            mark_else,
    output logic [PC_W-1:0] top_join,
    output logic [PC_W-1:0] top_epc,
    output logic [NT-1:0]   top_emask,
    output logic [NT-1:0]   top_pre,
    output logic            top_in_else,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty
);

    logic [PC_W-1:0]  join_q  [DEPTH];
    logic [PC_W-1:0]  epc_q   [DEPTH];
    logic [NT-1:0]    emask_q [DEPTH];
    logic [NT-1:0]    pre_q   [DEPTH];
    logic [DEPTH-1:0] phase_q;
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    wr_idx;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign count   = cnt_q;
    assign top_idx = empty ? '0 : IW'(cnt_q - CW'(1));
    assign wr_idx  = full ? '0 : IW'(cnt_q);

    assign top_join    = join_q[top_idx];
    assign top_epc     = epc_q[top_idx];
    assign top_emask   = emask_q[top_idx];
    assign top_pre     = pre_q[top_idx];
    assign top_in_else = phase_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (clr) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (push && !full) begin
            phase_q[wr_idx] <= 1'b0;
            cnt_q           <= cnt_q + CW'(1);
        end else if (pop && !empty) begin
            phase_q[top_idx] <= 1'b0;
            cnt_q            <= cnt_q - CW'(1);
        end else if (mark_else && !empty) begin
            phase_q[top_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clr) begin
            join_q[wr_idx]  <= push_join;
            epc_q[wr_idx]   <= push_epc;
            emask_q[wr_idx] <= push_emask;
            pre_q[wr_idx]   <= push_pre;
        end
    end

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R9
    AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R7
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH)); // R8
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n) (push && !clr) |=> cnt_q == $past(cnt_q) + CW'(1)); // R8

endmodule

// File: rtl/dv_mask_unit.sv
module dv_mask_unit
    import dv_pkg::*;
#(
    parameter int NUM_THREADS = 32,
    parameter int PC_W        = 32,
    parameter int STACK_DEPTH = 8,
    parameter int PC_STEP     = 4,
    localparam int CW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch_valid,
    input  logic [NUM_THREADS-1:0] launch_mask,
    input  logic [PC_W-1:0]        launch_pc,
    input  logic                   adv_valid,
    input  logic                   br_valid,
    input  logic [NUM_THREADS-1:0] br_cond,
    input  logic [PC_W-1:0]        br_taken_pc,
    input  logic [PC_W-1:0]        br_else_pc,
    input  logic [PC_W-1:0]        br_join_pc,
    input  logic                   else_valid,
    input  logic                   reconv_valid,
    input  logic [PC_W-1:0]        evt_join_pc,
    input  logic                   barrier_req,
    output logic                   issue_valid,
    output logic [NUM_THREADS-1:0] active_mask,
    output logic [PC_W-1:0]        cur_pc,
    output logic                   diverged,
    output logic [CW-1:0]          stack_depth,
    output logic                   uniform_br,
    output logic                   stack_ovf,
    output logic                   barrier_err
);

    localparam int NT = NUM_THREADS;

    dv_state_e       state_q, state_d;
    logic [NT-1:0]   mask_q, mask_d;
    logic [NT-1:0]   wmask_q, wmask_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            unif_q, unif_d;
    logic            ovf_q, ovf_d;
    logic            berr_q, berr_d;

    dv_event_e       ev;
    logic [NT-1:0]   tk_mask, nt_mask;
    logic            all_tk, none_tk;

    logic            stk_clr, stk_push, stk_pop, stk_mark;
    logic [PC_W-1:0] top_join, top_epc;
    logic [NT-1:0]   top_emask, top_pre;
    logic            top_in_else;
    logic [CW-1:0]   stk_cnt;
    logic            stk_full, stk_empty;
    logic            top_match;

    dv_evt_arb i_arb (
        .launch_valid (launch_valid),
        .br_valid     (br_valid),
        .else_valid   (else_valid),
        .reconv_valid (reconv_valid),
        .adv_valid    (adv_valid),
        .ev           (ev)
    );

    dv_split #(.NT(NT)) i_split (
        .active      (mask_q),
        .cond        (br_cond),
        .taken_mask  (tk_mask),
        .ntaken_mask (nt_mask),
        .all_taken   (all_tk),
        .none_taken  (none_tk)
    );

    dv_stack #(.NT(NT), .PC_W(PC_W), .DEPTH(STACK_DEPTH)) i_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (stk_clr),
        .push        (stk_push),
        .push_join   (br_join_pc),
        .push_epc    (br_else_pc),
        .push_emask  (nt_mask),
        .push_pre    (mask_q),
        .pop         (stk_pop),
        .mark_else   (stk_mark),
        .top_join    (top_join),
        .top_epc     (top_epc),
        .top_emask   (top_emask),
        .top_pre     (top_pre),
        .top_in_else (top_in_else),
        .count       (stk_cnt),
        .full        (stk_full),
        .empty       (stk_empty)
    );

    assign top_match = !stk_empty && (top_join == evt_join_pc);

    // Next-state and event handling
    always_comb begin
        state_d  = state_q;
        mask_d   = mask_q;
        wmask_d  = wmask_q;
        pc_d     = pc_q;
        ovf_d    = ovf_q;
        unif_d   = 1'b0;
        berr_d   = barrier_req && (state_q != ST_IDLE) && (mask_q != wmask_q);
        stk_clr  = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_mark = 1'b0;

        unique case (ev)
            EV_LAUNCH: begin
                if (launch_mask != '0) begin
                    state_d = ST_CONV;
                    mask_d  = launch_mask;
                    wmask_d = launch_mask;
                    pc_d    = launch_pc;
                    ovf_d   = 1'b0;
                    stk_clr = 1'b1;
                end
            end
            EV_BRANCH: begin
                if (state_q != ST_IDLE) begin
                    if (all_tk) begin
                        pc_d   = br_taken_pc;
                        unif_d = 1'b1;
                    end else if (none_tk) begin
                        pc_d   = br_else_pc;
                        unif_d = 1'b1;
                    end else if (stk_full) begin
                        ovf_d = 1'b1;
                    end else begin
                        stk_push = 1'b1;
                        mask_d   = tk_mask;
                        pc_d     = br_taken_pc;
                        state_d  = ST_DIV;
                    end
                end
            end
            EV_ELSE: begin
                if (state_q == ST_DIV && top_match && !top_in_else) begin
                    stk_mark = 1'b1;
                    mask_d   = top_emask;
                    pc_d     = top_epc;
                end
            end
            EV_RECONV: begin
                if (state_q == ST_DIV && top_match) begin
                    if (!top_in_else) begin
                        stk_mark = 1'b1;
                        mask_d   = top_emask;
                        pc_d     = top_epc;
                    end else begin
                        stk_pop = 1'b1;
                        mask_d  = top_pre;
                        pc_d    = top_join;
                        if (stk_cnt == CW'(1)) state_d = ST_CONV;
                    end
                end
            end
            EV_ADV: begin
                if (state_q != ST_IDLE) pc_d = pc_q + PC_W'(PC_STEP);
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            wmask_q <= '0;
            pc_q    <= '0;
            unif_q  <= 1'b0;
            ovf_q   <= 1'b0;
            berr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            wmask_q <= wmask_d;
            pc_q    <= pc_d;
            unif_q  <= unif_d;
            ovf_q   <= ovf_d;
            berr_q  <= berr_d;
        end
    end

    // Outputs
    always_comb begin
        issue_valid = (state_q != ST_IDLE);
        diverged    = (state_q == ST_DIV);
        active_mask = mask_q;
        cur_pc      = pc_q;
        stack_depth = stk_cnt;
        uniform_br  = unif_q;
        stack_ovf   = ovf_q;
        barrier_err = berr_q;
    end

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> active_mask != '0); // R12
    AST_MASK_IN_WARP: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> (active_mask & ~wmask_q) == '0); // R12
    AST_CONV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_CONV) |-> stack_depth == '0); // R7
    AST_DIV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) diverged |-> stack_depth != '0); // R4
    AST_UNIFORM_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) uniform_br |-> stack_depth == $past(stack_depth)); // R5
    AST_RESTORE_MASK: assert property (@(posedge clk) disable iff (!rst_n) stk_pop |=> active_mask == $past(top_pre)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(stack_ovf) |-> $stable(stack_depth) && $stable(active_mask)); // R9
    AST_BARRIER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) barrier_err |-> $past(barrier_req)); // R10

endmodule

// File: tb/test_dv_mask_unit.sv
module test_dv_mask_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 32;
    localparam int PCW  = 32;
    localparam int D    = 4;
    localparam int STEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_valid = 0, adv_valid = 0, br_valid = 0, else_valid = 0, reconv_valid = 0, barrier_req = 0;
    logic [NT-1:0] launch_mask = '0, br_cond = '0;
    logic [PCW-1:0] launch_pc = '0, br_taken_pc = '0, br_else_pc = '0, br_join_pc = '0, evt_join_pc = '0;
    logic issue_valid, diverged, uniform_br, stack_ovf, barrier_err;
    logic [NT-1:0] active_mask;
    logic [PCW-1:0] cur_pc;
    logic [2:0] stack_depth;

    always #(CLK_PERIOD/2) clk = ~clk;

    dv_mask_unit #(.NUM_THREADS(NT), .PC_W(PCW), .STACK_DEPTH(D), .PC_STEP(STEP)) i_dv_mask_unit (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_mask(launch_mask), .launch_pc(launch_pc),
        .adv_valid(adv_valid),
        .br_valid(br_valid), .br_cond(br_cond), .br_taken_pc(br_taken_pc),
        .br_else_pc(br_else_pc), .br_join_pc(br_join_pc),
        .else_valid(else_valid), .reconv_valid(reconv_valid), .evt_join_pc(evt_join_pc),
        .barrier_req(barrier_req),
        .issue_valid(issue_valid), .active_mask(active_mask), .cur_pc(cur_pc),
        .diverged(diverged), .stack_depth(stack_depth), .uniform_br(uniform_br),
        .stack_ovf(stack_ovf), .barrier_err(barrier_err)
    );

    typedef struct packed {
        logic           v;
        logic [NT-1:0]  mask;
        logic [PCW-1:0] pc;
        logic [2:0]     depth;
        logic           div;
        logic           unif;
        logic           ovf;
        logic           berr;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;

    // Bench model state
    logic           m_v = 0;
    logic [NT-1:0]  m_mask = '0, m_wmask = '0;
    logic [PCW-1:0] m_pc = '0;
    int             m_d = 0;
    logic           m_ovf = 0;
    logic [PCW-1:0] s_join [D];
    logic [PCW-1:0] s_epc  [D];
    logic [NT-1:0]  s_emask[D];
    logic [NT-1:0]  s_pre  [D];
    logic           s_inel [D];

    function automatic obs_t sample();
        obs_t o;
        o.v = issue_valid; o.mask = active_mask; o.pc = cur_pc; o.depth = stack_depth;
        o.div = diverged; o.unif = uniform_br; o.ovf = stack_ovf; o.berr = barrier_err;
        return o;
    endfunction

    task automatic clr_in();
        launch_valid = 0; adv_valid = 0; br_valid = 0; else_valid = 0;
        reconv_valid = 0; barrier_req = 0;
    endtask

    // Driver: inputs are set after a negedge; model computes the registered result
    task automatic step(string tag);
        obs_t e;
        logic [NT-1:0] tk, nk;
        logic e_unif, e_berr;
        e_unif = 0;
        e_berr = barrier_req && m_v && (m_mask != m_wmask);
        if (launch_valid) begin
            if (launch_mask != '0) begin
                m_v = 1; m_mask = launch_mask; m_wmask = launch_mask; m_pc = launch_pc;
                m_d = 0; m_ovf = 0;
            end
        end else if (br_valid) begin
            if (m_v) begin
                tk = m_mask & br_cond; nk = m_mask & ~br_cond;
                if (nk == '0) begin m_pc = br_taken_pc; e_unif = 1; end
                else if (tk == '0) begin m_pc = br_else_pc; e_unif = 1; end
                else if (m_d == D) m_ovf = 1;
                else begin
                    s_join[m_d] = br_join_pc; s_epc[m_d] = br_else_pc; s_emask[m_d] = nk;
                    s_pre[m_d] = m_mask; s_inel[m_d] = 0; m_d++;
                    m_mask = tk; m_pc = br_taken_pc;
                end
            end
        end else if (else_valid) begin
            if (m_d > 0 && s_join[m_d-1] == evt_join_pc && !s_inel[m_d-1]) begin
                s_inel[m_d-1] = 1; m_mask = s_emask[m_d-1]; m_pc = s_epc[m_d-1];
            end
        end else if (reconv_valid) begin
            if (m_d > 0 && s_join[m_d-1] == evt_join_pc) begin
                if (!s_inel[m_d-1]) begin
                    s_inel[m_d-1] = 1; m_mask = s_emask[m_d-1]; m_pc = s_epc[m_d-1];
                end else begin
                    m_mask = s_pre[m_d-1]; m_pc = s_join[m_d-1]; m_d--;
                end
            end
        end else if (adv_valid) begin
            if (m_v) m_pc = m_pc + PCW'(STEP);
        end
        e.v = m_v; e.mask = m_mask; e.pc = m_pc; e.depth = 3'(m_d); e.div = (m_d > 0);
        e.unif = e_unif; e.ovf = m_ovf; e.berr = e_berr;
        @(posedge clk);
        #1;
        clr_in();
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic do_launch(logic [NT-1:0] m, logic [PCW-1:0] pc, string tag);
        @(negedge clk); launch_valid = 1; launch_mask = m; launch_pc = pc; step(tag);
    endtask
    task automatic do_adv(string tag);
        @(negedge clk); adv_valid = 1; step(tag);
    endtask
    task automatic do_br(logic [NT-1:0] c, logic [PCW-1:0] t, logic [PCW-1:0] e, logic [PCW-1:0] j, string tag);
        @(negedge clk); br_valid = 1; br_cond = c; br_taken_pc = t; br_else_pc = e; br_join_pc = j; step(tag);
    endtask
    task automatic do_else(logic [PCW-1:0] j, string tag);
        @(negedge clk); else_valid = 1; evt_join_pc = j; step(tag);
    endtask
    task automatic do_reconv(logic [PCW-1:0] j, string tag);
        @(negedge clk); reconv_valid = 1; evt_join_pc = j; step(tag);
    endtask
    task automatic do_bar(string tag);
        @(negedge clk); barrier_req = 1; step(tag);
    endtask

    // Monitor: pops one expected item per cycle, sampled at the negedge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                obs_t a, e;
                string t;
                a = sample();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: got v=%0b mask=%h pc=%h d=%0d div=%0b u=%0b ovf=%0b berr=%0b exp v=%0b mask=%h pc=%h d=%0d div=%0b u=%0b ovf=%0b berr=%0b",
                             t, a.v, a.mask, a.pc, a.depth, a.div, a.unif, a.ovf, a.berr,
                             e.v, e.mask, e.pc, e.depth, e.div, e.unif, e.ovf, e.berr);
                end
                checks++;
                if (a.v && a.mask == '0) begin // R12
                    errors++;
                    $display("FAIL R12: got mask=%h with issue_valid, exp non-zero", a.mask);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout, exp finished run");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (sample() !== '0) begin
            errors++;
            $display("FAIL R1: got %h, exp all zero", sample());
        end

        // R11: events other than launch ignored in IDLE
        do_br(32'h0000_FFFF, 32'h200, 32'h300, 32'h400, "R11 idle branch");
        do_adv("R11 idle advance");
        // R2: zero-mask launch ignored
        do_launch('0, 32'h100, "R2 zero launch");
        do_launch('1, 32'h100, "R2 launch");
        do_adv("R3 advance 1");
        do_adv("R3 advance 2");
        do_bar("R10 barrier converged");
        do_br('1, 32'h180, 32'h190, 32'h1A0, "R5 uniform taken");
        do_br('0, 32'h1B0, 32'h1C0, 32'h1D0, "R5 uniform not taken");
        do_br(32'h0000_FFFF, 32'h200, 32'h300, 32'h400, "R4 divergent");
        do_bar("R10 barrier diverged");
        do_adv("R3 advance diverged");
        do_else(32'h999, "R6 else mismatched");
        do_br(32'h0000_00FF, 32'h240, 32'h280, 32'h2C0, "R8 nested push");
        do_br(32'hFFFF_0000, 32'h250, 32'h260, 32'h270, "R5 nested uniform");
        do_reconv(32'h270, "R7 reconverge mismatched");
        do_reconv(32'h2C0, "R7 reconverge in taken phase");
        do_else(32'h2C0, "R6 repeated else");
        do_reconv(32'h2C0, "R7 pop inner");
        do_else(32'h400, "R6 else outer");
        do_reconv(32'h400, "R7 pop outer");
        do_bar("R10 barrier after reconvergence");

        // R8/R9: fill a stack of depth 4, then overflow
        do_launch('1, 32'h1000, "R2 relaunch");
        do_br(32'h0000_FFFF, 32'h1100, 32'h1200, 32'h1300, "R8 level 1");
        do_br(32'h0000_00FF, 32'h1110, 32'h1210, 32'h1310, "R8 level 2");
        do_br(32'h0000_000F, 32'h1120, 32'h1220, 32'h1320, "R8 level 3");
        do_br(32'h0000_0003, 32'h1130, 32'h1230, 32'h1330, "R8 level 4");
        do_br(32'h0000_0001, 32'h1140, 32'h1240, 32'h1340, "R9 overflow");
        do_br('1, 32'h1150, 32'h1250, 32'h1350, "R9 uniform at full");
        do_reconv(32'h1330, "R8 unwind 4 switch");
        do_reconv(32'h1330, "R8 unwind 4 pop");
        do_reconv(32'h1320, "R8 unwind 3 switch");
        do_reconv(32'h1320, "R8 unwind 3 pop");
        do_launch(32'h0F0F_0F0F, 32'h2000, "R9 launch clears overflow");

        // R11: same-cycle priority
        @(negedge clk); br_valid = 1; adv_valid = 1; br_cond = 32'h0000_0F0F;
        br_taken_pc = 32'h2100; br_else_pc = 32'h2200; br_join_pc = 32'h2300;
        step("R11 branch over advance");
        @(negedge clk); else_valid = 1; reconv_valid = 1; evt_join_pc = 32'h2300;
        step("R11 else over reconverge");
        @(negedge clk); reconv_valid = 1; adv_valid = 1; evt_join_pc = 32'h2300;
        step("R11 reconverge over advance");
        @(negedge clk); launch_valid = 1; launch_mask = 32'h0000_0001; launch_pc = 32'h3000;
        br_valid = 1; br_cond = 32'h1;
        step("R11 launch over branch");
        @(negedge clk); launch_valid = 1; launch_mask = '0; adv_valid = 1;
        step("R11 zero launch blocks advance");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule